// File: doc/BRIEF.md
# Slow Windowed Receive Gain Controller

This block steers the receive gain index of a single channel. A power estimator outside the block produces one measurement per measurement period. Each measurement is a 7-bit code in dBFS, 1 dB per LSB, where a larger code means a weaker signal. The block accepts each measurement and places it in one of five regions, set by two nested threshold windows. It then lowers or raises the gain index by the step size programmed for that region. Nothing changes while the measurement sits inside the inner window.

Three saturating event counters run beside the window logic. They count large ADC overloads, small ADC overloads and digital-saturation events. Enough large overloads force a decrease, and that decrease takes priority over the window decision. Enough small overloads or saturation events only hold the gain from rising. An optional immediate mode lowers the gain on every single large overload. When the receiver is entered, an attack-delay timer keeps the algorithm idle until the receive path has settled. A rising edge on a sync pin can restart the counting window. The index is clamped to the range from 0 up to a programmable maximum.

The measurement input is a valid/ready stream. `pwr_ready` is tied high, so the block never applies back-pressure. A measurement is taken in every cycle in which `pwr_valid` is high, and a producer may present a new code in every cycle. All other pins are plain level or one-cycle pulse signals.

Top module: `agc_slow_window`

## Requirements
- R1: After reset, `gain_idx` is 0 and `gain_chg` is 0. The algorithm stays idle until the first `rx_enter` pulse, so measurements and events before that pulse change nothing.
- R2: An `rx_enter` pulse loads the attack delay D. The algorithm is idle in the pulse cycle and in the D cycles that follow, and during that time it ignores measurements and events. The first measurement that takes effect is one presented D+1 cycles after the pulse. A new pulse while the algorithm is active restarts the delay.
- R3: `pwr_ready` is always 1. A measurement is taken only in a cycle with `pwr_valid` high. Without one, the window holds the index.
- R4: If code + `out_hi_ofs` < `in_hi`, the measurement is above the outer high threshold, and the index falls by `out_hi_step`.
- R5: If code < `in_hi` but the outer high test of R4 fails, the index falls by `in_hi_step`. Both high-side tests are checked before the low-side tests.
- R6: If code > `in_lo` + `out_lo_ofs`, the measurement is below the outer low threshold, and the index rises by `out_lo_step`. A code inside both windows leaves the index unchanged.
- R7: If code > `in_lo` but the outer low test of R6 fails, the index rises by `in_lo_step`.
- R8: With `lg_imm_en` low, consider the large-overload count at a measurement, including a pulse in that same cycle. If it is at least `lg_ovl_lim` (a limit of 0 acts as 1), the index falls by `lg_ovl_step`. This decrease overrides any window decision.
- R9: With `lg_imm_en` high, each active-cycle `lg_ovl` pulse lowers the index by `lg_ovl_step` in that cycle. The decrease happens whether or not a measurement arrives. Such pulses are not counted.
- R10: If the small-overload count reaches `sm_ovl_lim`, or the saturation count reaches `sat_lim` (each counted including the current cycle, and each with a limit of 0 acting as 1), every increase at that measurement is blocked. Decreases are not affected.
- R11: The event counters count only in active cycles and stop at 15. All three clear at every measurement, at every forced decrease and at every sync clear. A pulse in a clearing cycle is dropped.
- R12: With `sync_en` high, a cycle where `sync_in` is 1 after having been 0 in the previous cycle clears the event counters. With `sync_en` low, `sync_in` has no effect.
- R13: A decrease stops at 0. An increase stops at `max_idx`, and an index already at or above `max_idx` is not raised.
- R14: `gain_chg` is 1 in exactly those cycles in which `gain_idx` holds a value different from its value one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_valid | input | 1 | Measurement valid |
| pwr_ready | output | 1 | Measurement ready, constant 1 |
| pwr_code | input | 7 | Measured power, dBFS, larger is weaker |
| lg_ovl | input | 1 | Large ADC overload event pulse |
| sm_ovl | input | 1 | Small ADC overload event pulse |
| dig_sat | input | 1 | Digital saturation event pulse |
| rx_enter | input | 1 | Receive-state entry pulse |
| sync_in | input | 1 | Counter sync input |
| sync_en | input | 1 | Enables the sync clear |
| max_idx | input | 7 | Highest allowed gain index |
| in_hi | input | 7 | Inner high threshold code |
| in_lo | input | 7 | Inner low threshold code |
| out_hi_ofs | input | 4 | Outer high offset in dB |
| out_lo_ofs | input | 4 | Outer low offset in dB |
| out_hi_step | input | 4 | Decrease above the outer high threshold |
| in_hi_step | input | 3 | Decrease above the inner high threshold only |
| out_lo_step | input | 4 | Increase below the outer low threshold |
| in_lo_step | input | 3 | Increase below the inner low threshold only |
| lg_ovl_lim | input | 4 | Large-overload count limit |
| lg_ovl_step | input | 4 | Forced decrease step |
| lg_imm_en | input | 1 | Immediate decrease on each large overload |
| sm_ovl_lim | input | 4 | Small-overload count limit |
| sat_lim | input | 4 | Saturation count limit |
| atk_dly | input | 6 | Attack delay in cycles |
| gain_idx | output | 7 | Current gain index |
| gain_chg | output | 1 | Index changed this cycle |

## Verification
A measurement or event that takes effect in a cycle changes `gain_idx` at the next rising edge. `gain_chg` rises at that same edge, so both results are due one edge after the stimulus. The exception is the attack delay, which holds everything off for D+1 cycles after the `rx_enter` pulse. The bench drives inputs on the falling edge and predicts the index with its own cycle model of the window, counters and timer. It compares `gain_idx` and `gain_chg` shortly after every rising edge, so each result is checked in exactly the cycle it is due.

// File: rtl/agc_pkg.sv
package agc_pkg;
  typedef enum logic [2:0] {
    ACT_HOLD,
    ACT_DEC_OVL,
    ACT_DEC_OUTER,
    ACT_DEC_INNER,
    ACT_INC_OUTER,
    ACT_INC_INNER
  } agc_act_e;

  localparam int N_EVT  = 3;
  localparam int EV_LG  = 0;
  localparam int EV_SM  = 1;
  localparam int EV_SAT = 2;
endpackage

// File: rtl/agc_event_ctr.sv
module agc_event_ctr #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             evt,
  input  logic             clr,
  input  logic [CNT_W-1:0] limit,
  output logic             hit
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_eff, lim_eff;

  always_comb begin
    cnt_eff = cnt_q;
    if (cnt_en && evt && cnt_q != CNT_MAX) cnt_eff = cnt_q + ONE;
    lim_eff = (limit == '0) ? ONE : limit;
    hit     = (cnt_eff >= lim_eff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else          cnt_q <= cnt_eff;
  end

  // R11
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt_q == '0);
  // R11
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !clr) |=> cnt_q == CNT_MAX);
endmodule

// File: rtl/agc_attack_timer.sv
module agc_attack_timer #(
  parameter int DLY_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DLY_W-1:0] dly,
  output logic             active
);
  logic             armed_q;
  logic [DLY_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      left_q  <= '0;
    end else if (start) begin
      armed_q <= 1'b1;
      left_q  <= dly;
    end else if (armed_q && left_q != '0) begin
      left_q  <= left_q - DLY_W'(1);
    end
  end

  assign active = armed_q && (left_q == '0);

  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (active == ($past(dly) == '0)));
  // R2
  stay_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !start) |=> active);
endmodule

// File: rtl/agc_window.sv
module agc_window #(
  parameter int PWR_W = 7,
  parameter int OFS_W = 4
) (
  input  logic [PWR_W-1:0] pwr,
  input  logic [PWR_W-1:0] thr_hi,
  input  logic [PWR_W-1:0] thr_lo,
  input  logic [OFS_W-1:0] ofs_hi,
  input  logic [OFS_W-1:0] ofs_lo,
  output logic             over_outer,
  output logic             over_inner,
  output logic             under_outer,
  output logic             under_inner
);
  localparam int CW = PWR_W + OFS_W + 1;

  logic [CW-1:0] p_w, hi_w, lo_w, p_plus, lo_plus;

  always_comb begin
    p_w     = CW'(pwr);
    hi_w    = CW'(thr_hi);
    lo_w    = CW'(thr_lo);
    p_plus  = p_w + CW'(ofs_hi);
    lo_plus = lo_w + CW'(ofs_lo);
    over_outer  = p_plus < hi_w;
    over_inner  = p_w < hi_w;
    under_outer = p_w > lo_plus;
    under_inner = p_w > lo_w;
  end
endmodule

// File: rtl/agc_slow_window.sv
module agc_slow_window
  import agc_pkg::*;
#(
  parameter int IDX_W   = 7,
  parameter int PWR_W   = 7,
  parameter int OFS_W   = 4,
  parameter int OSTEP_W = 4,
  parameter int ISTEP_W = 3,
  parameter int CNT_W   = 4,
  parameter int DLY_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pwr_valid,
  output logic               pwr_ready,
  input  logic [PWR_W-1:0]   pwr_code,
  input  logic               lg_ovl,
  input  logic               sm_ovl,
  input  logic               dig_sat,
  input  logic               rx_enter,
  input  logic               sync_in,
  input  logic               sync_en,
  input  logic [IDX_W-1:0]   max_idx,
  input  logic [PWR_W-1:0]   in_hi,
  input  logic [PWR_W-1:0]   in_lo,
  input  logic [OFS_W-1:0]   out_hi_ofs,
  input  logic [OFS_W-1:0]   out_lo_ofs,
  input  logic [OSTEP_W-1:0] out_hi_step,
  input  logic [ISTEP_W-1:0] in_hi_step,
  input  logic [OSTEP_W-1:0] out_lo_step,
  input  logic [ISTEP_W-1:0] in_lo_step,
  input  logic [CNT_W-1:0]   lg_ovl_lim,
  input  logic [OSTEP_W-1:0] lg_ovl_step,
  input  logic               lg_imm_en,
  input  logic [CNT_W-1:0]   sm_ovl_lim,
  input  logic [CNT_W-1:0]   sat_lim,
  input  logic [DLY_W-1:0]   atk_dly,
  output logic [IDX_W-1:0]   gain_idx,
  output logic               gain_chg
);
  function automatic logic [IDX_W-1:0] step_down(
    input logic [IDX_W-1:0] v, input logic [IDX_W-1:0] s);
    return (v < s) ? '0 : v - s;
  endfunction

  function automatic logic [IDX_W-1:0] step_up(
    input logic [IDX_W-1:0] v, input logic [IDX_W-1:0] s,
    input logic [IDX_W-1:0] mx);
    logic [IDX_W:0] sum;
    sum = {1'b0, v} + {1'b0, s};
    if (v >= mx)               return v;
    else if (sum > {1'b0, mx}) return mx;
    else                       return sum[IDX_W-1:0];
  endfunction

  logic             active, sample, force_dec, blocked, sync_q, sync_rise, ev_clr;
  logic             w_oo, w_oi, w_uo, w_ui;
  logic [N_EVT-1:0] ev_pulse, ev_hit;
  logic [CNT_W-1:0] ev_lim [N_EVT];
  agc_act_e         act;
  logic [IDX_W-1:0] idx_q, idx_next;
  logic             chg_q;

  assign pwr_ready = 1'b1;

  agc_attack_timer #(.DLY_W(DLY_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(rx_enter), .dly(atk_dly), .active(active));

  agc_window #(.PWR_W(PWR_W), .OFS_W(OFS_W)) u_window (
    .pwr(pwr_code), .thr_hi(in_hi), .thr_lo(in_lo),
    .ofs_hi(out_hi_ofs), .ofs_lo(out_lo_ofs),
    .over_outer(w_oo), .over_inner(w_oi), .under_outer(w_uo), .under_inner(w_ui));

  always_comb begin
    ev_pulse[EV_LG]  = lg_ovl && !lg_imm_en;
    ev_pulse[EV_SM]  = sm_ovl;
    ev_pulse[EV_SAT] = dig_sat;
    ev_lim[EV_LG]    = lg_ovl_lim;
    ev_lim[EV_SM]    = sm_ovl_lim;
    ev_lim[EV_SAT]   = sat_lim;
  end

  for (genvar g = 0; g < N_EVT; g++) begin : g_evt
    agc_event_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .cnt_en(active), .evt(ev_pulse[g]),
      .clr(ev_clr), .limit(ev_lim[g]), .hit(ev_hit[g]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 1'b0;
    else        sync_q <= sync_in;
  end

  always_comb begin
    sync_rise = sync_en && sync_in && !sync_q;
    sample    = active && pwr_valid;
    force_dec = active && (lg_imm_en ? lg_ovl : (sample && ev_hit[EV_LG]));
    blocked   = ev_hit[EV_SM] || ev_hit[EV_SAT];
    ev_clr    = sample || force_dec || sync_rise;

    act = ACT_HOLD;
    if (force_dec)              act = ACT_DEC_OVL;
    else if (sample) begin
      if (w_oo)                 act = ACT_DEC_OUTER;
      else if (w_oi)            act = ACT_DEC_INNER;
      else if (w_uo && !blocked) act = ACT_INC_OUTER;
      else if (w_ui && !blocked) act = ACT_INC_INNER;
    end

    case (act)
      ACT_DEC_OVL:   idx_next = step_down(idx_q, IDX_W'(lg_ovl_step));
      ACT_DEC_OUTER: idx_next = step_down(idx_q, IDX_W'(out_hi_step));
      ACT_DEC_INNER: idx_next = step_down(idx_q, IDX_W'(in_hi_step));
      ACT_INC_OUTER: idx_next = step_up(idx_q, IDX_W'(out_lo_step), max_idx);
      ACT_INC_INNER: idx_next = step_up(idx_q, IDX_W'(in_lo_step), max_idx);
      default:       idx_next = idx_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      chg_q <= 1'b0;
    end else begin
      idx_q <= idx_next;
      chg_q <= (idx_next != idx_q);
    end
  end

  assign gain_idx = idx_q;
  assign gain_chg = chg_q;

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> gain_idx == $past(gain_idx));
  // R14
  chg_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gain_chg == (gain_idx != $past(gain_idx)));
  // R10
  blocked_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && blocked) |=> gain_idx <= $past(gain_idx));
  // R8
  ovl_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_dec |=> gain_idx <= $past(gain_idx));
  // R13
  upper_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_INC_OUTER || act == ACT_INC_INNER)
      |=> (gain_idx <= $past(max_idx)) || (gain_idx == $past(gain_idx)));
  // R3
  ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_ready);
endmodule

// File: tb/agc_slow_window_tb.sv
module agc_slow_window_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_valid = 0, lg_ovl = 0, sm_ovl = 0, dig_sat = 0, rx_enter = 0;
  logic sync_in = 0, sync_en = 0, lg_imm_en = 0;
  logic [6:0] pwr_code = 0, max_idx = 0, in_hi = 0, in_lo = 0;
  logic [3:0] out_hi_ofs = 0, out_lo_ofs = 0, out_hi_step = 0, out_lo_step = 0;
  logic [2:0] in_hi_step = 0, in_lo_step = 0;
  logic [3:0] lg_ovl_lim = 0, lg_ovl_step = 0, sm_ovl_lim = 0, sat_lim = 0;
  logic [5:0] atk_dly = 0;
  logic       pwr_ready, gain_chg;
  logic [6:0] gain_idx;

  int n_chk = 0, n_fail = 0;
  string phase = "";

  int m_idx = 0, m_dcnt = 0;
  bit m_armed = 0, m_sync_q = 0;
  int m_cnt [3] = '{0, 0, 0};

  always #(CLK_PERIOD / 2) clk = ~clk;

  agc_slow_window u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_valid(pwr_valid), .pwr_ready(pwr_ready),
    .pwr_code(pwr_code), .lg_ovl(lg_ovl), .sm_ovl(sm_ovl), .dig_sat(dig_sat),
    .rx_enter(rx_enter), .sync_in(sync_in), .sync_en(sync_en), .max_idx(max_idx),
    .in_hi(in_hi), .in_lo(in_lo), .out_hi_ofs(out_hi_ofs), .out_lo_ofs(out_lo_ofs),
    .out_hi_step(out_hi_step), .in_hi_step(in_hi_step), .out_lo_step(out_lo_step),
    .in_lo_step(in_lo_step), .lg_ovl_lim(lg_ovl_lim), .lg_ovl_step(lg_ovl_step),
    .lg_imm_en(lg_imm_en), .sm_ovl_lim(sm_ovl_lim), .sat_lim(sat_lim),
    .atk_dly(atk_dly), .gain_idx(gain_idx), .gain_chg(gain_chg));

  task automatic chk(input string tag, input int actual, input int expected);
    n_chk++;
    if (actual != expected) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
    end
  endtask

  function automatic int lim1(input int l);
    return (l == 0) ? 1 : l;
  endfunction

  function automatic int dn(input int v, input int s);
    return (v < s) ? 0 : v - s;
  endfunction

  function automatic int up(input int v, input int s, input int mx);
    if (v >= mx) return v;
    return (v + s > mx) ? mx : v + s;
  endfunction

  // One clock: predict, let the edge pass, compare, return at the next falling edge.
  task automatic tick();
    bit act, smp, frc, blk, rise;
    int ce [3];
    int exp_idx;
    string why;
    act  = m_armed && (m_dcnt == 0);
    rise = sync_en && sync_in && !m_sync_q;
    ce[0] = m_cnt[0] + ((act && lg_ovl && !lg_imm_en && m_cnt[0] < 15) ? 1 : 0);
    ce[1] = m_cnt[1] + ((act && sm_ovl && m_cnt[1] < 15) ? 1 : 0);
    ce[2] = m_cnt[2] + ((act && dig_sat && m_cnt[2] < 15) ? 1 : 0);
    smp = act && pwr_valid;
    frc = act && (lg_imm_en ? lg_ovl : (smp && ce[0] >= lim1(int'(lg_ovl_lim))));
    blk = (ce[1] >= lim1(int'(sm_ovl_lim))) || (ce[2] >= lim1(int'(sat_lim)));
    exp_idx = m_idx;
    why = act ? "R3 no sample" : "R1/R2 idle";
    if (frc) begin
      exp_idx = dn(m_idx, int'(lg_ovl_step));
      why = lg_imm_en ? "R9 immediate dec" : "R8 overload dec";
    end else if (smp) begin
      if (int'(pwr_code) + int'(out_hi_ofs) < int'(in_hi)) begin
        exp_idx = dn(m_idx, int'(out_hi_step)); why = "R4 outer high dec";
      end else if (pwr_code < in_hi) begin
        exp_idx = dn(m_idx, int'(in_hi_step)); why = "R5 inner high dec";
      end else if (int'(pwr_code) > int'(in_lo) + int'(out_lo_ofs)) begin
        if (blk) why = "R10 blocked";
        else begin exp_idx = up(m_idx, int'(out_lo_step), int'(max_idx)); why = "R6 outer low inc"; end
      end else if (pwr_code > in_lo) begin
        if (blk) why = "R10 blocked";
        else begin exp_idx = up(m_idx, int'(in_lo_step), int'(max_idx)); why = "R7 inner low inc"; end
      end else why = "R6 in window hold";
    end
    if (exp_idx == 0 || exp_idx == int'(max_idx)) why = {why, " R13 edge"};
    if (smp || frc || rise) m_cnt = '{0, 0, 0};
    else m_cnt = ce;
    if (rx_enter) begin m_armed = 1; m_dcnt = int'(atk_dly); end
    else if (m_armed && m_dcnt != 0) m_dcnt--;
    m_sync_q = sync_in;
    @(posedge clk);
    #1;
    chk({phase, " ", why}, int'(gain_idx), exp_idx);
    chk({phase, " R14 strobe"}, int'(gain_chg), (exp_idx != m_idx) ? 1 : 0);
    m_idx = exp_idx;
    @(negedge clk);
  endtask

  task automatic drive(input bit v, input int p, input bit lg, input bit sm,
                       input bit st, input bit rx, input bit sy);
    pwr_valid = v; pwr_code = 7'(p); lg_ovl = lg; sm_ovl = sm; dig_sat = st;
    rx_enter = rx; sync_in = sy;
    tick();
  endtask

  task automatic idle_n(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic base_cfg();
    max_idx = 40; in_hi = 20; in_lo = 40; out_hi_ofs = 5; out_lo_ofs = 6;
    out_hi_step = 8; in_hi_step = 3; out_lo_step = 7; in_lo_step = 2;
    lg_ovl_lim = 3; lg_ovl_step = 5; lg_imm_en = 0; sm_ovl_lim = 2; sat_lim = 2;
    atk_dly = 4; sync_en = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    base_cfg();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    phase = "R1 reset";
    chk("R1 reset index", int'(gain_idx), 0);
    chk("R1 reset strobe", int'(gain_chg), 0);
    chk("R3 ready", int'(pwr_ready), 1);
    for (int i = 0; i < 3; i++) drive(1, 80, 0, 1, 0, 0, 0);

    phase = "R2 attack delay";
    drive(1, 60, 0, 0, 0, 1, 0);
    for (int i = 0; i < 12; i++) drive(1, 60, 0, 0, 0, 0, 0);
    phase = "R7 inner low";
    drive(1, 44, 0, 0, 0, 0, 0);
    phase = "R4 R5 high side";
    drive(1, 10, 0, 0, 0, 0, 0);
    drive(1, 17, 0, 0, 0, 0, 0);
    drive(0, 10, 0, 0, 0, 0, 0);
    for (int i = 0; i < 6; i++) drive(1, 2, 0, 0, 0, 0, 0);
    phase = "R6 window";
    drive(1, 30, 0, 0, 0, 0, 0);
    drive(1, 46, 0, 0, 0, 0, 0);

    phase = "R10 small overload block";
    drive(0, 0, 0, 1, 0, 0, 0);
    drive(1, 60, 0, 1, 0, 0, 0);
    drive(1, 60, 0, 0, 0, 0, 0);
    phase = "R10 saturation block";
    drive(0, 0, 0, 0, 1, 0, 0);
    drive(0, 0, 0, 0, 1, 0, 0);
    drive(1, 44, 0, 0, 0, 0, 0);
    drive(1, 10, 0, 1, 1, 0, 0);

    phase = "R8 overload priority";
    drive(1, 60, 0, 0, 0, 0, 0);
    drive(1, 60, 0, 0, 0, 0, 0);
    drive(0, 0, 1, 0, 0, 0, 0);
    drive(0, 0, 1, 0, 0, 0, 0);
    drive(1, 60, 1, 0, 0, 0, 0);
    drive(0, 0, 1, 0, 0, 0, 0);
    drive(1, 60, 0, 0, 0, 0, 0);

    phase = "R12 sync clear";
    drive(0, 0, 1, 0, 0, 0, 0);
    drive(0, 0, 1, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0, 1);
    drive(1, 60, 1, 0, 0, 0, 1);
    sync_en = 0;
    drive(0, 0, 1, 0, 0, 0, 0);
    drive(0, 0, 1, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0, 1);
    drive(1, 30, 1, 0, 0, 0, 1);
    sync_en = 1;

    phase = "R9 immediate";
    lg_imm_en = 1;
    drive(0, 0, 1, 0, 0, 0, 0);
    drive(1, 60, 1, 0, 0, 0, 0);
    drive(1, 60, 0, 0, 0, 0, 0);
    lg_imm_en = 0;

    phase = "R11 counter saturation";
    sm_ovl_lim = 15;
    for (int i = 0; i < 20; i++) drive(0, 0, 0, 1, 0, 0, 0);
    drive(1, 60, 0, 0, 0, 0, 0);
    drive(1, 60, 0, 0, 0, 0, 0);

    phase = "R2 restart";
    drive(1, 60, 0, 0, 0, 1, 0);
    for (int i = 0; i < 6; i++) drive(1, 10, 0, 0, 0, 0, 0);

    phase = "R13 max lowered";
    for (int i = 0; i < 8; i++) drive(1, 80, 0, 0, 0, 0, 0);
    max_idx = 20;
    drive(1, 80, 0, 0, 0, 0, 0);
    drive(1, 17, 0, 0, 0, 0, 0);

    phase = "random";
    for (int blk = 0; blk < 12; blk++) begin
      max_idx = 7'($urandom_range(10, 127)); in_hi = 7'($urandom_range(5, 40));
      in_lo = 7'($urandom_range(30, 90));
      out_hi_ofs = 4'($urandom); out_lo_ofs = 4'($urandom);
      out_hi_step = 4'($urandom); in_hi_step = 3'($urandom);
      out_lo_step = 4'($urandom); in_lo_step = 3'($urandom);
      lg_ovl_lim = 4'($urandom); lg_ovl_step = 4'($urandom);
      lg_imm_en = ($urandom_range(0, 3) == 0); sm_ovl_lim = 4'($urandom);
      sat_lim = 4'($urandom); atk_dly = 6'($urandom_range(0, 20));
      sync_en = 1'($urandom);
      for (int i = 0; i < 250; i++)
        drive($urandom_range(0, 2) != 0, $urandom_range(0, 127),
              $urandom_range(0, 9) == 0, $urandom_range(0, 5) == 0,
              $urandom_range(0, 7) == 0, $urandom_range(0, 120) == 0,
              $urandom_range(0, 6) == 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule